// File: doc/BRIEF.md
# Dual-Precedence Flag Register with Event Counters

This block is a two-register control/status slice on a simple request/acknowledge CPU bus. The first register holds two single-bit flags. Software can write both flags over the bus. Hardware can also write each flag through its own next-value input, but only while that flag's write-enable is high. When both sides write a flag in the same clock, a fixed per-flag precedence setting decides which value is kept. Software wins on flag 0 and hardware wins on flag 1.

The second register holds two 4-bit event counters that software can read but not write. Each counter adds one on every clock edge at which its matching flag is 1. A software write that loses a collision therefore leaves no trace in the flag itself. A software write that wins shows up as one extra count in the matching counter. An integrator attaches the bus to a CPU-side bridge and drives the hardware write ports from the datapath.

Top module: `prec_csr`

## Requirements
- R1: After a synchronous active-high reset, both flags and both counters are 0, `bus_ack` is low and `bus_rdata` is 0.
- R2: Every clock with `bus_req` high is answered by `bus_ack` high in the next clock only. Read data is valid in that acknowledge cycle and reflects the register contents before the request's edge. `bus_rdata` is 0 in every cycle without an acknowledge, and also in the acknowledge of a write.
- R3: A software write (`bus_req`=1, `bus_wr`=1) to byte address 0x0 with no hardware write enabled loads flag 0 from `bus_wdata[0]` and flag 1 from `bus_wdata[1]` at that clock edge.
- R4: With `hw_we[i]`=1, flag i loads `hw_next[i]` at the clock edge. With neither a software nor a hardware write, the flag holds its value.
- R5: Flag 0 gives software precedence: if a software write to 0x0 and `hw_we[0]` occur in the same cycle, flag 0 takes `bus_wdata[0]`.
- R6: Flag 1 gives hardware precedence: if a software write to 0x0 and `hw_we[1]` occur in the same cycle, flag 1 takes `hw_next[1]`.
- R7: Register 0x4 holds in bits [3:0] the counter of flag 0 and in bits [7:4] the counter of flag 1. Each counter increments by one at every clock edge where its flag holds 1 before that edge.
- R8: A counter at 15 that increments wraps to 0.
- R9: A read of 0x0 returns flag 0 in bit 0 and flag 1 in bit 1, with bits [31:2] zero. A read of 0x4 returns bits [31:8] zero.
- R10: A read of any address other than 0x0 and 0x4 returns 0. A write to such an address, or to 0x4, changes no flag and no counter.
- R11: With hardware writing 0 with enable to both flags continuously, three software writes of 0b11 to 0x0 leave 0x0 reading 0 and 0x4 reading 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Bus request, one transfer per cycle it is high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data, full register width |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Acknowledge, one cycle after the request |
| hw_next | input | NUM_FLAGS | Hardware next value per flag |
| hw_we | input | NUM_FLAGS | Hardware write-enable per flag |

## Verification
The bench goes after same-cycle collisions on each flag separately. A design with the precedence swapped or shared between the flags would keep the wrong value, and the counter readback would drift by one. It also checks the case where hardware continuously clears the flags. A design that counted the next value instead of the held flag, or that let the write mask the hardware clear, would read something other than 0x03. Long runs with both flags held high drive the counters past 15, and a missing wrap would show up as a nonzero carry into the neighbouring nibble or bit 8. Writes to the counter register and to unmapped or misaligned addresses must leave every readback unchanged, and reads from unmapped addresses must return zero.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int DATA_W    = 32;
  localparam int CTR_W     = 4;
  localparam int NUM_FLAGS = 2;
  localparam int FLAG_OFS  = 'h0;
  localparam int CTR_OFS   = 'h4;
  // bit i set: software wins a collision on flag i
  localparam logic [NUM_FLAGS-1:0] SW_PREC_MASK = 2'b01;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_FLAGS,
    SEL_CTRS
  } sel_e;
endpackage

// File: rtl/pcsr_flag.sv
module pcsr_flag #(
  parameter bit SW_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_we,
  input  logic sw_d,
  input  logic hw_we,
  input  logic hw_d,
  output logic q
);
  logic d_next;

  generate
    if (SW_WINS) begin : g_sw_prec
      always_comb begin
        d_next = q;
        if (hw_we) d_next = hw_d;
        if (sw_we) d_next = sw_d;
      end
      AST_SW_WINS_COLLISION: assert property (@(posedge clk) disable iff (rst)
        (sw_we && hw_we) |=> (q == $past(sw_d))); // R5
    end else begin : g_hw_prec
      always_comb begin
        d_next = q;
        if (sw_we) d_next = sw_d;
        if (hw_we) d_next = hw_d;
      end
      AST_HW_WINS_COLLISION: assert property (@(posedge clk) disable iff (rst)
        (sw_we && hw_we) |=> (q == $past(hw_d))); // R6
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d_next;
  end

  AST_SW_ONLY_LOADS: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !hw_we) |=> (q == $past(sw_d))); // R3
  AST_HW_ONLY_LOADS: assert property (@(posedge clk) disable iff (rst)
    (hw_we && !sw_we) |=> (q == $past(hw_d))); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !hw_we) |=> $stable(q)); // R4
endmodule

// File: rtl/pcsr_ctr.sv
module pcsr_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (inc) cnt <= cnt + ONE;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
    inc |=> (cnt == W'($past(cnt) + ONE))); // R7
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(cnt)); // R7
  AST_CTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && (&cnt)) |=> (cnt == '0)); // R8
endmodule

// File: rtl/pcsr_bus.sv
module pcsr_bus
  import pcsr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DW     = 32,
  parameter int NF     = 2,
  parameter int CW     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic [NF-1:0]      flags,
  input  logic [NF*CW-1:0]   ctrs,
  output logic               flag_we,
  output logic [NF-1:0]      flag_wd,
  output logic [DW-1:0]      rdata,
  output logic               ack
);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(FLAG_OFS);
  localparam logic [ADDR_W-1:0] A_CTRS  = ADDR_W'(CTR_OFS);

  sel_e          sel;
  logic [DW-1:0] rd_val;

  always_comb begin
    if (addr == A_FLAGS)     sel = SEL_FLAGS;
    else if (addr == A_CTRS) sel = SEL_CTRS;
    else                     sel = SEL_NONE;
  end

  assign flag_we = req && wr && (sel == SEL_FLAGS);
  assign flag_wd = wdata[NF-1:0];

  always_comb begin
    case (sel)
      SEL_FLAGS: rd_val = DW'(flags);
      SEL_CTRS:  rd_val = DW'(ctrs);
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack   <= req;
      rdata <= (req && !wr) ? rd_val : '0;
    end
  end

  AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req |=> ack); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !req |=> !ack); // R2
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ack |-> (rdata == '0)); // R2
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && !wr && sel == SEL_NONE) |=> (rdata == '0)); // R10
endmodule

// File: rtl/prec_csr.sv
module prec_csr
  import pcsr_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_req,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_ack,
  input  logic [NUM_FLAGS-1:0] hw_next,
  input  logic [NUM_FLAGS-1:0] hw_we
);
  localparam int CTR_BITS = NUM_FLAGS * CTR_W;

  logic [NUM_FLAGS-1:0] flags;
  logic [CTR_BITS-1:0]  ctrs;
  logic                 flag_we;
  logic [NUM_FLAGS-1:0] flag_wd;

  pcsr_bus #(
    .ADDR_W(ADDR_W), .DW(DATA_W), .NF(NUM_FLAGS), .CW(CTR_W)
  ) u_bus (
    .clk(clk), .rst(rst),
    .req(bus_req), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .flags(flags), .ctrs(ctrs),
    .flag_we(flag_we), .flag_wd(flag_wd),
    .rdata(bus_rdata), .ack(bus_ack)
  );

  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_fld
      pcsr_flag #(.SW_WINS(SW_PREC_MASK[i])) u_flag (
        .clk(clk), .rst(rst),
        .sw_we(flag_we), .sw_d(flag_wd[i]),
        .hw_we(hw_we[i]), .hw_d(hw_next[i]),
        .q(flags[i])
      );
      pcsr_ctr #(.W(CTR_W)) u_ctr (
        .clk(clk), .rst(rst),
        .inc(flags[i]),
        .cnt(ctrs[i*CTR_W +: CTR_W])
      );
    end
  endgenerate
endmodule

// File: tb/sim_prec_csr.sv
`timescale 1ns/1ps
module sim_prec_csr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ack;
  logic [1:0]  hw_next = '0;
  logic [1:0]  hw_we = '0;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    armed = 1'b0;

  // behavioural reference state
  int m_f0, m_f1, m_c0, m_c1, m_ack;
  longint m_rdata;

  always #10 clk = ~clk;

  prec_csr u0 (
    .clk(clk), .rst(rst),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .hw_next(hw_next), .hw_we(hw_we)
  );

  function automatic longint model_read(input int a);
    if (a == 0) return longint'(m_f1 * 2 + m_f0);
    if (a == 4) return longint'(m_c1 * 16 + m_c0);
    return 0;
  endfunction

  always @(posedge clk) begin
    armed = 1'b1;
    if (rst) begin
      m_f0 = 0; m_f1 = 0; m_c0 = 0; m_c1 = 0; m_ack = 0; m_rdata = 0;
    end else begin
      automatic int  nf0 = m_f0;
      automatic int  nf1 = m_f1;
      automatic bit  sw_hit = bus_req && bus_wr && (bus_addr == 4'h0);
      m_rdata = (bus_req && !bus_wr) ? model_read(int'(bus_addr)) : 0;
      m_ack   = bus_req ? 1 : 0;
      // flag 0: software applied last (wins)
      if (hw_we[0]) nf0 = int'(hw_next[0]);
      if (sw_hit)   nf0 = int'(bus_wdata[0]);
      // flag 1: hardware applied last (wins)
      if (sw_hit)   nf1 = int'(bus_wdata[1]);
      if (hw_we[1]) nf1 = int'(hw_next[1]);
      m_c0 = (m_c0 + m_f0) % 16;
      m_c1 = (m_c1 + m_f1) % 16;
      m_f0 = nf0;
      m_f1 = nf1;
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      vectors++;
      if (bus_ack !== m_ack[0] || longint'(bus_rdata) !== m_rdata) begin
        miscompares++;
        $display("FAIL %s cycle compare: ack=%0d rdata=%08h, expected ack=%0d rdata=%08h",
                 cur_req, bus_ack, bus_rdata, m_ack, m_rdata);
      end
    end
  end

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic read_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    #1;
    vectors++;
    if (bus_ack !== 1'b1 || bus_rdata !== exp) begin
      miscompares++;
      $display("FAIL %s read %h: ack=%0d rdata=%08h, expected ack=1 rdata=%08h",
               tag, a, bus_ack, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog R2: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    read_check(4'h0, 32'h0, "R1");
    read_check(4'h4, 32'h0, "R1");

    // R11: hardware clears both flags every cycle while software writes 0b11
    cur_req = "R11";
    hw_we = 2'b11; hw_next = 2'b00;
    bus_write(4'h0, 32'h3);
    bus_write(4'h0, 32'h3);
    bus_write(4'h0, 32'h3);
    idle(1);
    read_check(4'h0, 32'h0, "R11");
    read_check(4'h4, 32'h3, "R11");

    // R3 / R9: software write, upper write bits ignored on readback
    cur_req = "R3";
    hw_we = 2'b00;
    bus_write(4'h0, 32'hFFFF_FFFE);
    read_check(4'h0, 32'h2, "R3/R9");

    // R4: hardware write with enable, then hold without it
    cur_req = "R4";
    @(negedge clk); hw_we = 2'b01; hw_next = 2'b01;
    @(negedge clk); hw_we = 2'b00; hw_next = 2'b10;
    idle(2);
    read_check(4'h0, 32'h3, "R4");

    // R5 / R6: collisions in both directions
    cur_req = "R5/R6";
    @(negedge clk);
    hw_we = 2'b11; hw_next = 2'b11;
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h0;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; hw_we = 2'b00;
    read_check(4'h0, 32'h2, "R5/R6 collide sw=0 hw=1");
    @(negedge clk);
    hw_we = 2'b11; hw_next = 2'b00;
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h3;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; hw_we = 2'b00;
    read_check(4'h0, 32'h1, "R5/R6 collide sw=1 hw=0");

    // R10: writes to counter and unmapped addresses have no effect
    cur_req = "R10";
    @(negedge clk); hw_we = 2'b11; hw_next = 2'b00;
    @(negedge clk); hw_we = 2'b00;
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_write(4'h8, 32'h3);
    bus_write(4'h1, 32'h3);
    read_check(4'h0, 32'h0, "R10 flags untouched");
    read_check(4'h8, 32'h0, "R10");
    read_check(4'hC, 32'h0, "R10");
    read_check(4'h2, 32'h0, "R10");

    // R7 / R8: counters run and wrap, checked every cycle against the model
    cur_req = "R7/R8";
    @(negedge clk); hw_we = 2'b11; hw_next = 2'b11;
    @(negedge clk); hw_we = 2'b00;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 4'h4;
    end
    @(negedge clk); bus_req = 1'b0;

    // R2: mixed back-to-back traffic with hardware activity
    cur_req = "R2";
    begin
      automatic int unsigned lcg = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        lcg = lcg * 1103515245 + 12345;
        bus_req   = lcg[16];
        bus_wr    = lcg[17];
        bus_addr  = lcg[19] ? 4'h4 : (lcg[18] ? lcg[23:20] : 4'h0);
        bus_wdata = {lcg[31:2], lcg[25:24]};
        hw_we     = lcg[27:26];
        hw_next   = lcg[29:28];
      end
      @(negedge clk);
      bus_req = 1'b0; hw_we = 2'b00;
    end
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule